// File: doc/BRIEF.md
# Linear-Time Memory Self-Test Sequencer

This block runs the linear-time functional tests on a synchronous single-port RAM. It can run up to three test families, always in the same order: a solid fill, a checkerboard and a march. The block drives the RAM address, write data, write enable and read enable itself. It checks every word read back against the value it expects. Each test family includes a second pass that uses inverted data, so every cell is checked at both polarities.

A test run starts with a one-cycle `start` pulse that carries a three-bit enable mask. While the run is in progress, `busy` is high. When the run finishes, `done` pulses for one cycle and `pass` gives the verdict. If a read miscompares, the block keeps the address of the first mismatching read and the identifier of the family that was running. This record is sticky until the next accepted start. The RAM must return read data one cycle after the read is issued.

Top module: `mbist_seq`

## Requirements
- R1: The solid family (mask bit 0, family ID 0) runs four sweeps in ascending address order. It writes all-ones to every word, reads every word, writes all-zeros to every word, then reads every word again.
- R2: The checkerboard family (mask bit 1, family ID 1) runs four ascending sweeps. The first sweep writes all-ones to words with an even address and all-zeros to words with an odd address. The second sweep reads and verifies that pattern. The third sweep writes the inverse pattern, and the fourth sweep reads and verifies it.
- R3: The march family (mask bit 2, family ID 2) runs three sweeps in ascending address order:
  - It first writes all-zeros to every word.
  - For each address, it then reads and expects zeros, and in the next cycle writes ones to the same word.
  - For each address, it then reads and expects ones, and in the next cycle writes zeros.
- R4: Each cycle of a run issues exactly one RAM operation. `done` is seen high (4n·s + 4n·c + 5n·m + 1) rising edges after the edge that accepts `start`. Here n is the word count, and s, c and m are the mask bits. An empty mask gives `done` one edge later with `pass` high.
- R5: Read data is compared with the expected word in the cycle after the read is issued, which matches a one-cycle read latency.
- R6: The first mismatching read clears `pass` and records its address in `fail_addr` and its family ID in `fail_pat`. Later mismatches do not change this record. An accepted start clears it.
- R7: The enabled families run in the order solid, checkerboard, march. A family whose mask bit is 0 issues no operations.
- R8: A `start` pulse while `busy` is high has no effect on the sequence of operations or on the completion time.
- R9: `done` is high for exactly one cycle, and only while `busy` is low.
- R10: Write data is always all-zeros or all-ones across the word. Write enable and read enable are never high together. Both are low while the block is idle.
- R11: After reset, `busy` and `done` are low, `pass` is high, and `fail_addr` and `fail_pat` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request, accepted only when idle |
| pat_en | input | 3 | Family enable mask: bit 0 solid, bit 1 checkerboard, bit 2 march |
| mem_addr | output | ADDR_W | RAM word address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after the read |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | No mismatch seen since the last accepted start |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_pat | output | 2 | Family ID of the first mismatch |

## Verification
The assertions check the following on every cycle:
- The RAM strobes are exclusive, and write data is always replicated across the word.
- The bus is quiet while the block is idle.
- `done` is a single-cycle pulse that does not overlap `busy`, and `busy` cannot drop without `done`.
- The failure record stays fixed once it has been set.

Only the bench's scenarios can show whether the operation order and data of each family are right, whether completion comes at the exact cycle, and whether injected stuck-at cells are located at the right address and family. The bench shows this by recording the RAM operations and comparing them against sequences built from the requirements.

// File: rtl/mbist_seq.sv
module mbist_seq #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        pat_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [1:0]        fail_pat
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
  localparam logic [1:0] FAM_CHK   = 2'd1;
  localparam logic [1:0] FAM_MARCH = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} state_t;

  state_t            st;
  logic [1:0]        fam, ph;
  logic [ADDR_W-1:0] addr;
  logic              sub;
  logic [2:0]        en_r;
  logic              cmp_v, cmp_e;
  logic [ADDR_W-1:0] cmp_a;
  logic [1:0]        cmp_f;
  logic              fail_r;

  logic run, is_march, rw_ph, rd, bit_sc, wbit, ebit, step, last_ph, mism;
  logic       nx_ok, st_ok;
  logic [1:0] nx_fam, st_fam;

  assign run      = (st == S_RUN);
  assign is_march = (fam == FAM_MARCH);
  assign rw_ph    = is_march && (ph != 2'd0);
  assign rd       = run && (is_march ? (rw_ph && !sub) : ph[0]);
  assign bit_sc   = (fam == FAM_CHK) ? (~addr[0] ^ ph[1]) : ~ph[1];
  assign wbit     = is_march ? (ph == 2'd1) : bit_sc;
  assign ebit     = is_march ? (ph == 2'd2) : bit_sc;
  assign step     = !rw_ph || sub;
  assign last_ph  = is_march ? (ph == 2'd2) : (ph == 2'd3);
  assign mism     = cmp_v && (mem_rdata != {DATA_W{cmp_e}});

  assign mem_addr  = addr;
  assign mem_wdata = {DATA_W{wbit}};
  assign mem_re    = rd;
  assign mem_we    = run && !rd;
  assign busy      = (st != S_IDLE);
  assign pass      = !fail_r;

  always_comb begin
    nx_ok  = 1'b0;
    nx_fam = 2'd0;
    for (int i = 2; i >= 0; i--) begin
      if (en_r[i] && (i > int'(fam))) begin
        nx_ok  = 1'b1;
        nx_fam = 2'(i);
      end
    end
    st_ok  = |pat_en;
    st_fam = pat_en[0] ? 2'd0 : (pat_en[1] ? 2'd1 : 2'd2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      fam       <= '0;
      ph        <= '0;
      addr      <= '0;
      sub       <= 1'b0;
      en_r      <= '0;
      cmp_v     <= 1'b0;
      cmp_e     <= 1'b0;
      cmp_a     <= '0;
      cmp_f     <= '0;
      fail_r    <= 1'b0;
      fail_addr <= '0;
      fail_pat  <= '0;
      done      <= 1'b0;
    end else begin
      done  <= 1'b0;
      cmp_v <= rd;
      cmp_e <= ebit;
      cmp_a <= addr;
      cmp_f <= fam;
      if (mism && !fail_r) begin
        fail_r    <= 1'b1;
        fail_addr <= cmp_a;
        fail_pat  <= cmp_f;
      end
      case (st)
        S_IDLE: if (start) begin
          fail_r    <= 1'b0;
          fail_addr <= '0;
          fail_pat  <= '0;
          en_r      <= pat_en;
          addr      <= '0;
          ph        <= '0;
          sub       <= 1'b0;
          fam       <= st_fam;
          st        <= st_ok ? S_RUN : S_DRAIN;
        end
        S_RUN: begin
          if (rw_ph) sub <= ~sub;
          if (step) begin
            if (addr == LAST_ADDR) begin
              addr <= '0;
              if (last_ph) begin
                ph <= '0;
                if (nx_ok) fam <= nx_fam;
                else       st  <= S_DRAIN;
              end else begin
                ph <= ph + 2'd1;
              end
            end else begin
              addr <= addr + 1'b1;
            end
          end
        end
        default: begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
      endcase
    end
  end
endmodule

module mbist_seq_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic [ADDR_W-1:0] fail_addr,
  input logic              mem_we,
  input logic              mem_re,
  input logic [DATA_W-1:0] mem_wdata
);
  // R10
  we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  // R10
  wdata_rep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == '0 || mem_wdata == '1));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_we || mem_re));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
  // R6
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && !(start && !busy)) |=> (!pass && $stable(fail_addr)));
endmodule

bind mbist_seq mbist_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .pass(pass), .fail_addr(fail_addr), .mem_we(mem_we), .mem_re(mem_re),
  .mem_wdata(mem_wdata)
);

// File: tb/mbist_seq_bench.sv
`timescale 1ns/1ps
module mbist_seq_bench;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int N      = 1 << ADDR_W;
  localparam int MAXOP  = 512;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [2:0]        pat_en = '0;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic              mem_we, mem_re;
  logic [DATA_W-1:0] mem_rdata;
  logic              busy, done, pass;
  logic [ADDR_W-1:0] fail_addr;
  logic [1:0]        fail_pat;

  always #2 clk = ~clk;

  mbist_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mbist_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_en(pat_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .pass(pass),
    .fail_addr(fail_addr), .fail_pat(fail_pat)
  );

  // RAM model with up to two stuck-at bits
  logic [DATA_W-1:0] ram [N];
  logic        f_en [2];
  int          f_addr [2];
  int          f_bit [2];
  logic        f_val [2];

  function automatic logic [DATA_W-1:0] apply_f(input int a, input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r = d;
    for (int k = 0; k < 2; k++)
      if (f_en[k] && f_addr[k] == a) r[f_bit[k]] = f_val[k];
    return r;
  endfunction

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= apply_f(int'(mem_addr), mem_wdata);
    if (mem_re) mem_rdata <= ram[mem_addr];
  end

  // Operation trace (kind 1 = write, 2 = read)
  int   nrec, nexp;
  logic rec;
  int   r_kind [MAXOP];
  int   r_addr [MAXOP];
  int   r_bit  [MAXOP];
  int   e_kind [MAXOP];
  int   e_addr [MAXOP];
  int   e_bit  [MAXOP];

  always @(negedge clk) begin
    if (rec && (mem_we || mem_re) && nrec < MAXOP) begin
      r_kind[nrec] = mem_we ? 1 : 2;
      r_addr[nrec] = int'(mem_addr);
      r_bit[nrec]  = mem_we ? ((mem_wdata == '1) ? 1 : ((mem_wdata == '0) ? 0 : 9)) : 0;
      nrec++;
    end
  end

  int nchk = 0, nfail = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int k, input int a, input int b);
    if (nexp < MAXOP) begin
      e_kind[nexp] = k; e_addr[nexp] = a; e_bit[nexp] = b; nexp++;
    end
  endtask

  task automatic build(input logic [2:0] m);
    nexp = 0;
    if (m[0]) begin
      for (int a = 0; a < N; a++) push(1, a, 1);
      for (int a = 0; a < N; a++) push(2, a, 0);
      for (int a = 0; a < N; a++) push(1, a, 0);
      for (int a = 0; a < N; a++) push(2, a, 0);
    end
    if (m[1]) begin
      for (int a = 0; a < N; a++) push(1, a, (a % 2 == 0) ? 1 : 0);
      for (int a = 0; a < N; a++) push(2, a, 0);
      for (int a = 0; a < N; a++) push(1, a, (a % 2 == 0) ? 0 : 1);
      for (int a = 0; a < N; a++) push(2, a, 0);
    end
    if (m[2]) begin
      for (int a = 0; a < N; a++) push(1, a, 0);
      for (int a = 0; a < N; a++) begin push(2, a, 0); push(1, a, 1); end
      for (int a = 0; a < N; a++) begin push(2, a, 0); push(1, a, 0); end
    end
  endtask

  task automatic cmp_trace(input string req);
    int bad = -1;
    check(nrec == nexp, req, "operation count", nrec, nexp);
    for (int i = 0; i < nexp && i < nrec; i++)
      if (bad < 0 && (r_kind[i] != e_kind[i] || r_addr[i] != e_addr[i] || r_bit[i] != e_bit[i]))
        bad = i;
    if (bad >= 0)
      check(1'b0, req, $sformatf("op %0d kind/addr/bit %0d/%0d/%0d vs", bad,
            r_kind[bad], r_addr[bad], r_bit[bad]),
            e_kind[bad] * 100 + e_addr[bad], e_bit[bad]);
    else
      check(1'b1, req, "operation order", 0, 0);
  endtask

  // Start a run; optionally pulse start again at cycle inj with mask 7
  task automatic run(input logic [2:0] m, input int inj, output int cyc);
    nrec = 0;
    rec  = 1'b1;
    @(negedge clk);
    start = 1'b1; pat_en = m;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (cyc == inj) begin start = 1'b1; pat_en = 3'b111; end
      else if (cyc == inj + 1) start = 1'b0;
      if (done || cyc > 2000) break;
    end
    rec = 1'b0;
    start = 1'b0;
  endtask

  task automatic t_reset;
    check(!busy && !done, "R11", "busy/done after reset", {busy, done}, 0);
    check(pass, "R11", "pass after reset", pass, 1);
    check(fail_addr == 0 && fail_pat == 0, "R11", "fail record after reset", fail_addr, 0);
    check(!mem_we && !mem_re, "R10", "idle strobes", {mem_we, mem_re}, 0);
  endtask

  task automatic t_family(input logic [2:0] m, input string req, input int ops);
    int cyc;
    build(m);
    run(m, -5, cyc);
    cmp_trace(req);
    check(cyc == ops + 1, "R4", $sformatf("%s completion cycle", req), cyc, ops + 1);
    check(pass, req, "pass on fault-free RAM", pass, 1);
    @(negedge clk);
    check(!done, "R9", "done width", done, 0);
  endtask

  task automatic t_all;
    int cyc;
    build(3'b111);
    run(3'b111, -5, cyc);
    cmp_trace("R7");
    check(cyc == 13 * N + 1, "R4", "all families completion", cyc, 13 * N + 1);
  endtask

  task automatic t_skip;
    int cyc;
    build(3'b101);
    run(3'b101, -5, cyc);
    cmp_trace("R7");
    check(cyc == 9 * N + 1, "R7", "skip checkerboard completion", cyc, 9 * N + 1);
  endtask

  task automatic t_empty;
    int cyc;
    run(3'b000, -5, cyc);
    check(nrec == 0, "R4", "empty mask operations", nrec, 0);
    check(cyc == 1 && pass, "R4", "empty mask completion", cyc, 1);
  endtask

  task automatic t_busy_start;
    int cyc;
    build(3'b010);
    run(3'b010, 10, cyc);
    cmp_trace("R8");
    check(cyc == 4 * N + 1, "R8", "completion with start while busy", cyc, 4 * N + 1);
  endtask

  task automatic t_fault(input logic [2:0] m, input int a, input logic v, input int fp,
                         input string req);
    int cyc;
    f_en[0] = 1'b1; f_addr[0] = a; f_bit[0] = 3; f_val[0] = v;
    run(m, -5, cyc);
    f_en[0] = 1'b0;
    check(!pass, req, "pass with stuck cell", pass, 0);
    check(fail_addr == a, "R5", $sformatf("%s fail address", req), fail_addr, a);
    check(fail_pat == fp, "R6", $sformatf("%s fail family", req), fail_pat, fp);
  endtask

  task automatic t_first_fail;
    int cyc;
    f_en[0] = 1'b1; f_addr[0] = 3; f_bit[0] = 0; f_val[0] = 1'b0;
    f_en[1] = 1'b1; f_addr[1] = 9; f_bit[1] = 7; f_val[1] = 1'b0;
    run(3'b111, -5, cyc);
    f_en[0] = 1'b0; f_en[1] = 1'b0;
    check(fail_addr == 3 && fail_pat == 0, "R6", "first failure kept",
          fail_addr * 10 + fail_pat, 30);
    check(cyc == 13 * N + 1, "R4", "failing run completion", cyc, 13 * N + 1);
    run(3'b001, -5, cyc);
    check(pass && fail_addr == 0, "R6", "record cleared by new start", pass, 1);
  endtask

  initial begin
    f_en[0] = 1'b0; f_en[1] = 1'b0;
    rec = 1'b0; nrec = 0; nexp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_family(3'b001, "R1", 4 * N);
    t_family(3'b010, "R2", 4 * N);
    t_family(3'b100, "R3", 5 * N);
    t_all();
    t_skip();
    t_empty();
    t_busy_start();
    t_fault(3'b001, 5, 1'b0, 0, "R1");
    t_fault(3'b010, 5, 1'b0, 1, "R2");
    t_fault(3'b100, 5, 1'b0, 2, "R3");
    t_fault(3'b100, 2, 1'b1, 2, "R3");
    t_first_fail();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #400000;
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule